// File: doc/BRIEF.md
# Accumulator ALU with flags

This block is the 8-bit arithmetic and logic datapath of a small accumulator machine. Each cycle it takes an opcode, the working register W, a file operand f (or a literal k in its place) and the incoming carry, digit-carry and zero flags. It returns a result, a destination select that sends the result to W or back to f, and the updated flags. Arithmetic covers add, add-with-carry, subtract and subtract-with-borrow. Unary and logic work covers AND, OR, XOR, complement, increment, decrement, clear, move and rotate through carry.

The same stage also produces control-flow information for the sequencer around it. A skip condition is raised for increment or decrement that reaches zero, and for bit tests. A next program-counter value is produced that, for a computed jump, adds W as a signed offset to PC+1. The sequencer owns fetch, stack and memory and consumes these outputs.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, all outputs are zero. The reset is asynchronous and takes effect without a clock edge.
- R2: Add (`OP_ADDW`) gives (operand + W) mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the 8-bit result is zero.
- R3: Add-with-carry (`OP_ADDC`) gives operand + W + C. C is set when the 9-bit sum exceeds FFh. DC is the carry out of bit 3. Z comes from the 8-bit result only.
- R4: Subtract (`OP_SUBW`) gives operand − W, formed as operand + ~W + 1. C is 1 when no borrow occurs (operand ≥ W), so 04h − 05h gives FFh with C=0. DC is the carry out of bit 3 of that sum. Z is set on a zero result.
- R5: Subtract-with-borrow (`OP_SUBB`) gives operand − W − (1 − C). For example, 04h − 05h with C=0 gives FEh. The flags are formed as in R4.
- R6: AND, OR, XOR, complement, increment, decrement and clear update only Z. C and DC pass through unchanged. Clear always yields 00h with Z=1.
- R7: Move (`OP_MOVF`) passes the operand through and leaves all three flags equal to their inputs.
- R8: Rotate-left gives {operand[6:0], C} and moves operand bit 7 into C. Rotate-right gives {C, operand[7:1]} and moves operand bit 0 into C. Both rotations update Z and leave DC unchanged.
- R9: Increment-skip-if-zero and decrement-skip-if-zero produce operand ± 1, raise `skip_o` when that result is zero, and change no flag.
- R10: Bit-test-skip-if-clear raises `skip_o` when operand bit `bit_sel_i` is 0. Bit-test-skip-if-set raises it when that bit is 1. Both pass the operand through unchanged. No other operation raises `skip_o`.
- R11: The computed jump (`OP_JMPW`) gives `pc_next_o` = PC + 1 + sign-extended W, modulo 2^PC_W. For example, with PC=212h, W=80h gives 193h and W=FEh gives 211h. Every other operation gives PC + 1.
- R12: `dest_f_i`=0 directs the result to W and `dest_f_i`=1 directs it back to f. When `use_k_i`=1, k replaces f as the operand and the destination is forced to W.
- R13: With `REG_OUT`=1, every output reflects the inputs present at the previous rising clock edge. Before that edge, the outputs still show the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code (package enum `acc_op_e`) |
| w_i | input | DATA_W | Working register value |
| f_i | input | DATA_W | File operand |
| k_i | input | DATA_W | Literal operand |
| use_k_i | input | 1 | Take k instead of f as the operand |
| dest_f_i | input | 1 | Destination select: 0 = W, 1 = f |
| bit_sel_i | input | BIT_W | Bit index for bit tests |
| c_i | input | 1 | Carry flag in |
| dc_i | input | 1 | Digit-carry flag in |
| z_i | input | 1 | Zero flag in |
| pc_i | input | PC_W | Address of the current instruction |
| res_o | output | DATA_W | Result |
| dest_f_o | output | 1 | Effective destination, 1 = f |
| c_o | output | 1 | Carry flag out |
| dc_o | output | 1 | Digit-carry flag out |
| z_o | output | 1 | Zero flag out |
| skip_o | output | 1 | Skip the next instruction |
| pc_next_o | output | PC_W | Next program-counter value |

## Verification
The bench builds the block with DATA_W=8, PC_W=10 and REG_OUT=1. This makes the nibble boundary at bit 3 and the byte carry at bit 7 the exact edges the vectors probe. The 10-bit counter lets a jump from 3FFh wrap to a small address. The registered variant enables the in-module clocked properties and allows a one-cycle latency check against the previous result. A mid-run asynchronous reset confirms that outputs clear between clock edges.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADDW  = 5'd0,
      OP_ADDC  = 5'd1,
      OP_SUBW  = 5'd2,
      OP_SUBB  = 5'd3,
      OP_AND   = 5'd4,
      OP_IOR   = 5'd5,
      OP_XOR   = 5'd6,
      OP_COMF  = 5'd7,
      OP_INCF  = 5'd8,
      OP_DECF  = 5'd9,
      OP_CLR   = 5'd10,
      OP_MOVF  = 5'd11,
      OP_RLC   = 5'd12,
      OP_RRC   = 5'd13,
      OP_INCSZ = 5'd14,
      OP_DECSZ = 5'd15,
      OP_BTSC  = 5'd16,
      OP_BTSS  = 5'd17,
      OP_JMPW  = 5'd18
   } acc_op_e;

   typedef struct packed {
      logic c;
      logic dc;
      logic z;
   } acc_flags_t;

   function automatic logic op_is_arith(acc_op_e op);
      return op inside {OP_ADDW, OP_ADDC, OP_SUBW, OP_SUBB};
   endfunction

   function automatic logic op_is_zonly(acc_op_e op);
      return op inside {OP_AND, OP_IOR, OP_XOR, OP_COMF, OP_INCF, OP_DECF, OP_CLR};
   endfunction

   function automatic logic op_is_rot(acc_op_e op);
      return op inside {OP_RLC, OP_RRC};
   endfunction

   function automatic logic op_is_skip(acc_op_e op);
      return op inside {OP_INCSZ, OP_DECSZ, OP_BTSC, OP_BTSS};
   endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  acc_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] w,
   input  logic              c_in,
   output logic [DATA_W-1:0] sum,
   output logic              c_out,
   output logic              dc_out
);
   localparam int HALF = DATA_W / 2;

   logic              is_sub;
   logic              cin;
   logic [DATA_W-1:0] w_eff;
   logic [HALF:0]     lo_sum;
   logic [DATA_W:0]   full_sum;

   always_comb begin
      is_sub = (op == OP_SUBW) || (op == OP_SUBB);
      unique case (op)
         OP_ADDC, OP_SUBB: cin = c_in;
         OP_SUBW:          cin = 1'b1;
         default:          cin = 1'b0;
      endcase
      w_eff = is_sub ? ~w : w;
   end

   assign lo_sum   = {1'b0, a[HALF-1:0]} + {1'b0, w_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
   assign full_sum = {1'b0, a} + {1'b0, w_eff} + {{DATA_W{1'b0}}, cin};

   assign sum    = full_sum[DATA_W-1:0];
   assign c_out  = full_sum[DATA_W];
   assign dc_out = lo_sum[HALF];

   // Low half of the full sum must agree with the nibble adder.
   always_comb begin
      nib_agree_chk: assert (full_sum[HALF-1:0] == lo_sum[HALF-1:0])
         else $error("nibble adder disagrees with full adder");
   end

endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  acc_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] w,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   always_comb begin
      c_out = c_in;
      unique case (op)
         OP_AND:           res = a & w;
         OP_IOR:           res = a | w;
         OP_XOR:           res = a ^ w;
         OP_COMF:          res = ~a;
         OP_INCF, OP_INCSZ: res = a + ONE;
         OP_DECF, OP_DECSZ: res = a - ONE;
         OP_CLR:           res = '0;
         OP_RLC: begin
            res   = {a[DATA_W-2:0], c_in};
            c_out = a[DATA_W-1];
         end
         OP_RRC: begin
            res   = {c_in, a[DATA_W-1:1]};
            c_out = a[0];
         end
         default:          res = a;
      endcase
   end

endmodule

// File: rtl/acc_alu_flow.sv
module acc_alu_flow
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PC_W   = 10,
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  acc_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] ures,
   input  logic [DATA_W-1:0] w,
   input  logic [BIT_W-1:0]  bit_sel,
   input  logic [PC_W-1:0]   pc,
   output logic              skip,
   output logic [PC_W-1:0]   pc_next
);
   localparam int EXT_W = PC_W - DATA_W;

   logic [PC_W-1:0] pc_inc;
   logic [PC_W-1:0] w_sext;
   logic            tested;

   assign pc_inc = pc + PC_W'(1);
   assign w_sext = {{EXT_W{w[DATA_W-1]}}, w};
   assign tested = a[bit_sel];

   always_comb begin
      unique case (op)
         OP_INCSZ, OP_DECSZ: skip = (ures == '0);
         OP_BTSC:            skip = ~tested;
         OP_BTSS:            skip = tested;
         default:            skip = 1'b0;
      endcase
      pc_next = (op == OP_JMPW) ? pc_inc + w_sext : pc_inc;
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int  DATA_W  = 8,
   parameter int  PC_W    = 10,
   parameter bit  REG_OUT = 1'b1,
   localparam int BIT_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] w_i,
   input  logic [DATA_W-1:0] f_i,
   input  logic [DATA_W-1:0] k_i,
   input  logic              use_k_i,
   input  logic              dest_f_i,
   input  logic [BIT_W-1:0]  bit_sel_i,
   input  logic              c_i,
   input  logic              dc_i,
   input  logic              z_i,
   input  logic [PC_W-1:0]   pc_i,
   output logic [DATA_W-1:0] res_o,
   output logic              dest_f_o,
   output logic              c_o,
   output logic              dc_o,
   output logic              z_o,
   output logic              skip_o,
   output logic [PC_W-1:0]   pc_next_o
);

   // Elaboration-time parameter checks
   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_data_w
      $error("DATA_W must be even and at least 4");
   end
   if (PC_W <= DATA_W) begin : g_bad_pc_w
      $error("PC_W must exceed DATA_W");
   end

   acc_op_e           op;
   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] a_sum;
   logic              a_c;
   logic              a_dc;
   logic [DATA_W-1:0] u_res;
   logic              u_c;
   logic              f_skip;
   logic [PC_W-1:0]   f_pc;

   assign op   = acc_op_e'(op_i);
   assign opnd = use_k_i ? k_i : f_i;

   acc_alu_arith #(.DATA_W(DATA_W)) arith_i (
      .op(op), .a(opnd), .w(w_i), .c_in(c_i),
      .sum(a_sum), .c_out(a_c), .dc_out(a_dc)
   );

   acc_alu_unary #(.DATA_W(DATA_W)) unary_i (
      .op(op), .a(opnd), .w(w_i), .c_in(c_i),
      .res(u_res), .c_out(u_c)
   );

   acc_alu_flow #(.DATA_W(DATA_W), .PC_W(PC_W)) flow_i (
      .op(op), .a(opnd), .ures(u_res), .w(w_i), .bit_sel(bit_sel_i),
      .pc(pc_i), .skip(f_skip), .pc_next(f_pc)
   );

   // Result and flag selection
   logic [DATA_W-1:0] nx_res;
   acc_flags_t        nx_fl;
   logic              nx_dest;

   always_comb begin
      nx_res  = op_is_arith(op) ? a_sum : u_res;
      nx_fl   = '{c: c_i, dc: dc_i, z: z_i};
      nx_dest = use_k_i ? 1'b0 : dest_f_i;
      if (op_is_arith(op)) begin
         nx_fl.c  = a_c;
         nx_fl.dc = a_dc;
         nx_fl.z  = (nx_res == '0);
      end else if (op_is_zonly(op)) begin
         nx_fl.z  = (nx_res == '0);
      end else if (op_is_rot(op)) begin
         nx_fl.c  = u_c;
         nx_fl.z  = (nx_res == '0);
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o     <= '0;
            dest_f_o  <= 1'b0;
            c_o       <= 1'b0;
            dc_o      <= 1'b0;
            z_o       <= 1'b0;
            skip_o    <= 1'b0;
            pc_next_o <= '0;
         end else begin
            res_o     <= nx_res;
            dest_f_o  <= nx_dest;
            c_o       <= nx_fl.c;
            dc_o      <= nx_fl.dc;
            z_o       <= nx_fl.z;
            skip_o    <= f_skip;
            pc_next_o <= f_pc;
         end
      end

      // R6
      zonly_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         op_is_zonly(op) |=> (c_o == $past(c_i) && dc_o == $past(dc_i)))
         else $error("logic op altered C or DC");

      // R7
      move_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (op == OP_MOVF) |=> ({c_o, dc_o, z_o} == $past({c_i, dc_i, z_i})))
         else $error("move altered a flag");

      // R12
      literal_dest_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
         use_k_i |=> !dest_f_o)
         else $error("literal operand sent result to f");

      // R11
      plain_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (op != OP_JMPW) |=> (pc_next_o == $past(pc_i) + PC_W'(1)))
         else $error("non-jump did not step PC by one");

      // R10
      skip_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !op_is_skip(op) |=> !skip_o)
         else $error("skip raised by non-skip op");

      // R2
      arith_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         op_is_arith(op) |=> (z_o == (res_o == '0)))
         else $error("Z disagrees with arithmetic result");
   end else begin : g_comb
      assign res_o     = nx_res;
      assign dest_f_o  = nx_dest;
      assign c_o       = nx_fl.c;
      assign dc_o      = nx_fl.dc;
      assign z_o       = nx_fl.z;
      assign skip_o    = f_skip;
      assign pc_next_o = f_pc;
   end

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
   import acc_alu_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int PW = 10;
   localparam int NV = 32;

   typedef struct packed {
      acc_op_e   op;
      logic [7:0] w;
      logic [7:0] f;
      logic [7:0] k;
      logic       use_k;
      logic       d;
      logic [2:0] bsel;
      logic [9:0] pc;
      logic [2:0] fl_in;
      logic [7:0] e_res;
      logic       e_dest;
      logic [2:0] e_fl;
      logic       e_skip;
      logic [9:0] e_pcn;
   } vec_t;

   // fields: op, w, f, k, use_k, d, bsel, pc, {c,dc,z} in, res, dest, {c,dc,z} out, skip, pc_next
   localparam vec_t VECS [NV] = '{
      '{OP_ADDW, 8'h05, 8'h04, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h09, 1'b0, 3'b000, 1'b0, 10'h011},
      '{OP_ADDW, 8'h08, 8'h08, 8'h00, 1'b0, 1'b1, 3'd0, 10'h010, 3'b000, 8'h10, 1'b1, 3'b010, 1'b0, 10'h011},
      '{OP_ADDW, 8'h80, 8'h80, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h00, 1'b0, 3'b101, 1'b0, 10'h011},
      '{OP_ADDC, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b100, 8'h00, 1'b0, 3'b111, 1'b0, 10'h011},
      '{OP_ADDC, 8'h01, 8'h02, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h03, 1'b0, 3'b000, 1'b0, 10'h011},
      '{OP_SUBW, 8'h05, 8'h04, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'hFF, 1'b0, 3'b000, 1'b0, 10'h011},
      '{OP_SUBW, 8'h05, 8'h05, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h00, 1'b0, 3'b111, 1'b0, 10'h011},
      '{OP_SUBB, 8'h05, 8'h04, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'hFE, 1'b0, 3'b000, 1'b0, 10'h011},
      '{OP_SUBB, 8'h05, 8'h09, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b100, 8'h04, 1'b0, 3'b110, 1'b0, 10'h011},
      '{OP_AND,  8'h0F, 8'hF0, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b110, 8'h00, 1'b0, 3'b111, 1'b0, 10'h011},
      '{OP_IOR,  8'h0F, 8'hF0, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b001, 8'hFF, 1'b0, 3'b000, 1'b0, 10'h011},
      '{OP_XOR,  8'hAA, 8'hAA, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b100, 8'h00, 1'b0, 3'b101, 1'b0, 10'h011},
      '{OP_COMF, 8'h00, 8'h55, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b010, 8'hAA, 1'b0, 3'b010, 1'b0, 10'h011},
      '{OP_INCF, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h00, 1'b0, 3'b001, 1'b0, 10'h011},
      '{OP_DECF, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b100, 8'h00, 1'b0, 3'b101, 1'b0, 10'h011},
      '{OP_CLR,  8'h00, 8'h37, 8'h00, 1'b0, 1'b1, 3'd0, 10'h010, 3'b110, 8'h00, 1'b1, 3'b111, 1'b0, 10'h011},
      '{OP_MOVF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b010, 8'h00, 1'b0, 3'b010, 1'b0, 10'h011},
      '{OP_RLC,  8'h00, 8'h81, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b010, 8'h02, 1'b0, 3'b110, 1'b0, 10'h011},
      '{OP_RLC,  8'h00, 8'h80, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h00, 1'b0, 3'b101, 1'b0, 10'h011},
      '{OP_RRC,  8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h00, 1'b0, 3'b101, 1'b0, 10'h011},
      '{OP_RRC,  8'h00, 8'h02, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b100, 8'h81, 1'b0, 3'b000, 1'b0, 10'h011},
      '{OP_INCSZ,8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h00, 1'b0, 3'b000, 1'b1, 10'h011},
      '{OP_DECSZ,8'h00, 8'h05, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b001, 8'h04, 1'b0, 3'b001, 1'b0, 10'h011},
      '{OP_DECSZ,8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 10'h010, 3'b000, 8'h00, 1'b0, 3'b000, 1'b1, 10'h011},
      '{OP_BTSC, 8'h00, 8'hF7, 8'h00, 1'b0, 1'b0, 3'd3, 10'h010, 3'b000, 8'hF7, 1'b0, 3'b000, 1'b1, 10'h011},
      '{OP_BTSS, 8'h00, 8'hF7, 8'h00, 1'b0, 1'b0, 3'd3, 10'h010, 3'b000, 8'hF7, 1'b0, 3'b000, 1'b0, 10'h011},
      '{OP_BTSS, 8'h00, 8'h08, 8'h00, 1'b0, 1'b0, 3'd3, 10'h010, 3'b000, 8'h08, 1'b0, 3'b000, 1'b1, 10'h011},
      '{OP_JMPW, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 10'h212, 3'b000, 8'h00, 1'b0, 3'b000, 1'b0, 10'h193},
      '{OP_JMPW, 8'hFE, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 10'h212, 3'b000, 8'h00, 1'b0, 3'b000, 1'b0, 10'h211},
      '{OP_JMPW, 8'h05, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 10'h3FF, 3'b000, 8'h00, 1'b0, 3'b000, 1'b0, 10'h005},
      '{OP_ADDW, 8'h05, 8'h11, 8'hFB, 1'b1, 1'b1, 3'd0, 10'h010, 3'b000, 8'h00, 1'b0, 3'b111, 1'b0, 10'h011},
      '{OP_SUBW, 8'h01, 8'hFF, 8'h10, 1'b1, 1'b1, 3'd0, 10'h010, 3'b000, 8'h0F, 1'b0, 3'b100, 1'b0, 10'h011}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    op_i = '0;
   logic [DW-1:0] w_i = '0, f_i = '0, k_i = '0;
   logic          use_k_i = 1'b0, dest_f_i = 1'b0;
   logic [2:0]    bit_sel_i = '0;
   logic          c_i = 1'b0, dc_i = 1'b0, z_i = 1'b0;
   logic [PW-1:0] pc_i = '0;
   logic [DW-1:0] res_o;
   logic          dest_f_o, c_o, dc_o, z_o, skip_o;
   logic [PW-1:0] pc_next_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_alu #(.DATA_W(DW), .PC_W(PW), .REG_OUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .w_i(w_i), .f_i(f_i), .k_i(k_i),
      .use_k_i(use_k_i), .dest_f_i(dest_f_i), .bit_sel_i(bit_sel_i),
      .c_i(c_i), .dc_i(dc_i), .z_i(z_i), .pc_i(pc_i),
      .res_o(res_o), .dest_f_o(dest_f_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o),
      .skip_o(skip_o), .pc_next_o(pc_next_o)
   );

   function automatic string tag_of(vec_t v);
      if (v.use_k) return "R12";
      case (v.op)
         OP_ADDW:  return "R2";
         OP_ADDC:  return "R3";
         OP_SUBW:  return "R4";
         OP_SUBB:  return "R5";
         OP_MOVF:  return "R7";
         OP_RLC, OP_RRC: return "R8";
         OP_INCSZ, OP_DECSZ: return "R9";
         OP_BTSC, OP_BTSS: return "R10";
         OP_JMPW:  return "R11";
         default:  return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h (res,dest,c,dc,z,skip,pc_next)", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] outs();
      return {res_o, dest_f_o, c_o, dc_o, z_o, skip_o, pc_next_o, 1'b0};
   endfunction

   task automatic drive(vec_t v);
      op_i = v.op; w_i = v.w; f_i = v.f; k_i = v.k;
      use_k_i = v.use_k; dest_f_i = v.d; bit_sel_i = v.bsel; pc_i = v.pc;
      {c_i, dc_i, z_i} = v.fl_in;
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      drive(VECS[0]);
      repeat (2) @(negedge clk);
      check("R1", outs(), 24'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         @(negedge clk);
         check(tag_of(VECS[i]), outs(),
               {VECS[i].e_res, VECS[i].e_dest, VECS[i].e_fl, VECS[i].e_skip, VECS[i].e_pcn, 1'b0});
      end

      // R13: output holds previous result until the next rising edge
      op_i = OP_ADDW; w_i = 8'h01; f_i = 8'h01; use_k_i = 1'b0; dest_f_i = 1'b0;
      {c_i, dc_i, z_i} = 3'b000; pc_i = 10'h010;
      #1;
      check("R13", {16'h0, res_o}, {16'h0, VECS[NV-1].e_res});
      @(negedge clk);
      check("R13", {16'h0, res_o}, {16'h0, 8'h02});

      // R1: asynchronous reset mid-run clears outputs without an edge
      op_i = OP_IOR; w_i = 8'h3C; f_i = 8'h00; pc_i = 10'h100;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", outs(), 24'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6", {16'h0, res_o}, {16'h0, 8'h3C});

      finish_run();
   end

endmodule